// File: doc/BRIEF.md
# Paged Program Counter Loader

This block holds the program counter of a small microcontroller core whose program memory is split into 512-word pages. On each enabled instruction cycle the counter takes one of five next values. It can advance by one. It can take a jump target that carries nine address bits from the instruction. It can take a call target that carries eight address bits with bit 8 forced to zero. It can take a computed-jump value written into its low byte. It can take a return address from the hardware stack. For jumps, calls and low-byte writes, the top address bit is copied from the page-select bit of the status register.

The core's decoder drives a source code, the literal address field, the value destined for the low byte, the page bit and the stack's top entry. The block returns the current address and that address plus one. The second value is what the stack saves on a call.

The control is a single selection state, one of five named sources, evaluated each enabled cycle:
- STEP: the counter advances by one.
- JUMP: the counter takes the jump target.
- CALL: the counter takes the call target.
- LOWWR: the counter takes the low-byte write.
- RET: the counter takes the stack return.

Synchronous reset overrides every source and places the counter at the final word of the final page. From that word a plain advance wraps to address zero.

Top module: `paged_pc_loader`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_o` becomes 0x3FF after that edge, and `pc_plus1_o` becomes 0x000.
- R2: With `cyc_en` low and `rst` low, `pc_o` keeps its value whatever the other inputs carry.
- R3: Source code 0 (STEP) with `cyc_en` high sets `pc_o` to its old value plus one, modulo 1024, so 0x3FF is followed by 0x000.
- R4: Source code 1 (JUMP) loads `pc_o` = {`page_bit`, `addr_field[8:0]`}.
- R5: Source code 2 (CALL) loads `pc_o` = {`page_bit`, 1'b0, `addr_field[7:0]`}. Bit 8 of `addr_field` has no effect.
- R6: Source code 3 (LOWWR) loads `pc_o` = {`page_bit`, 1'b0, `low_byte`}.
- R7: Source code 4 (RET) loads `pc_o` = `ret_addr`, and `page_bit` has no effect.
- R8: `pc_plus1_o` always equals `pc_o` + 1 modulo 1024.
- R9: Reset takes priority over `cyc_en` low and over any source code.
- R10: Source codes 5, 6 and 7 behave as STEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_en | input | 1 | Instruction-cycle enable |
| src_sel | input | 3 | Next-address source code (0 STEP, 1 JUMP, 2 CALL, 3 LOWWR, 4 RET) |
| addr_field | input | 9 | Literal address field of the instruction |
| low_byte | input | 8 | Value written to the low counter byte |
| page_bit | input | 1 | Page-select bit from the status register |
| ret_addr | input | 10 | Top-of-stack return address |
| pc_o | output | 10 | Current program counter |
| pc_plus1_o | output | 10 | Current counter plus one, for the stack |

## Verification
The bench builds the block with its defaults of two 512-word pages. This gives a 10-bit counter, so the reset vector 0x3FF and the wrap to zero are reached in one step. With only two pages the page bit is a single wire, so both pages are visited by jumps and calls. Call targets are driven with address-field bit 8 set to show that the bit is dropped. A jump to the last word followed by a step repeats the wrap away from reset.

// File: rtl/pc_loader_pkg.sv
package pc_loader_pkg;

    typedef enum logic [2:0] {
        SRC_STEP  = 3'd0,
        SRC_JUMP  = 3'd1,
        SRC_CALL  = 3'd2,
        SRC_LOWWR = 3'd3,
        SRC_RET   = 3'd4
    } pc_src_e;

endpackage

// File: rtl/pc_incr.sv
module pc_incr #(
    parameter int W = 10
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);

    always_comb begin
        nxt = cur + W'(1);
    end

endmodule

// File: rtl/pc_target_mux.sv
module pc_target_mux
    import pc_loader_pkg::*;
#(
    parameter int JMP_W = 9,
    parameter int LOW_W = 8,
    parameter int PG_W  = 1,
    localparam int PC_W = JMP_W + PG_W,
    localparam int GAP  = JMP_W - LOW_W
) (
    input  logic [2:0]       src_sel,
    input  logic [PC_W-1:0]  step_val,
    input  logic [JMP_W-1:0] addr_field,
    input  logic [LOW_W-1:0] low_byte,
    input  logic [PG_W-1:0]  page_bit,
    input  logic [PC_W-1:0]  ret_addr,
    output logic [PC_W-1:0]  nxt
);

    pc_src_e src;

    always_comb begin
        src = pc_src_e'(src_sel);
    end

    always_comb begin
        unique case (src)
            SRC_JUMP:  nxt = {page_bit, addr_field};
            SRC_CALL:  nxt = {page_bit, {GAP{1'b0}}, addr_field[LOW_W-1:0]};
            SRC_LOWWR: nxt = {page_bit, {GAP{1'b0}}, low_byte};
            SRC_RET:   nxt = ret_addr;
            default:   nxt = step_val;
        endcase
    end

endmodule

// File: rtl/paged_pc_loader.sv
module paged_pc_loader
    import pc_loader_pkg::*;
#(
    parameter int PAGE_WORDS = 512,
    parameter int PAGES      = 2,
    parameter int LOW_W      = 8,
    localparam int JMP_W     = $clog2(PAGE_WORDS),
    localparam int PG_W      = $clog2(PAGES),
    localparam int PC_W      = JMP_W + PG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_en,
    input  logic [2:0]       src_sel,
    input  logic [JMP_W-1:0] addr_field,
    input  logic [LOW_W-1:0] low_byte,
    input  logic [PG_W-1:0]  page_bit,
    input  logic [PC_W-1:0]  ret_addr,
    output logic [PC_W-1:0]  pc_o,
    output logic [PC_W-1:0]  pc_plus1_o
);

    localparam logic [PC_W-1:0] RESET_PC = '1;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] pc_nxt;

    pc_incr #(.W(PC_W)) u_incr (
        .cur (pc_q),
        .nxt (pc_inc)
    );

    pc_target_mux #(
        .JMP_W (JMP_W),
        .LOW_W (LOW_W),
        .PG_W  (PG_W)
    ) u_mux (
        .src_sel    (src_sel),
        .step_val   (pc_inc),
        .addr_field (addr_field),
        .low_byte   (low_byte),
        .page_bit   (page_bit),
        .ret_addr   (ret_addr),
        .nxt        (pc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
        end else if (cyc_en) begin
            pc_q <= pc_nxt;
        end
    end

    always_comb begin
        pc_o       = pc_q;
        pc_plus1_o = pc_inc;
    end

    // R1 / R9: reset wins over every source
    a_r1_reset_vector: assert property (@(posedge clk)
        rst |=> (pc_o == RESET_PC));

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !cyc_en |=> $stable(pc_o));

    a_r3_step_advances: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && src_sel == 3'd0) |=> (pc_o == PC_W'($past(pc_o) + PC_W'(1))));

    a_r5_call_bit8_clear: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && src_sel == 3'd2) |=> (pc_o[JMP_W-1] == 1'b0));

    a_r7_return_load: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && src_sel == 3'd4) |=> (pc_o == $past(ret_addr)));

endmodule

// File: tb/paged_pc_loader_bench.sv
`timescale 1ns/1ps
module paged_pc_loader_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       cyc_en;
    logic [2:0] src_sel;
    logic [8:0] addr_field;
    logic [7:0] low_byte;
    logic       page_bit;
    logic [9:0] ret_addr;
    logic [9:0] pc_o;
    logic [9:0] pc_plus1_o;

    always #2 clk = ~clk;

    paged_pc_loader u_paged_pc_loader (
        .clk        (clk),
        .rst        (rst),
        .cyc_en     (cyc_en),
        .src_sel    (src_sel),
        .addr_field (addr_field),
        .low_byte   (low_byte),
        .page_bit   (page_bit),
        .ret_addr   (ret_addr),
        .pc_o       (pc_o),
        .pc_plus1_o (pc_plus1_o)
    );

    typedef struct {
        logic [9:0] pc;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    logic [9:0] model_pc;
    int         vectors = 0;
    int         miscompares = 0;

    task automatic apply(input logic r, input logic en, input logic [2:0] s,
                         input logic [8:0] a, input logic [7:0] lb,
                         input logic pg, input logic [9:0] ra, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; cyc_en = en; src_sel = s; addr_field = a;
        low_byte = lb; page_bit = pg; ret_addr = ra;
        if (r) model_pc = 10'h3FF;
        else if (en) begin
            case (s)
                3'd1: model_pc = {pg, a};
                3'd2: model_pc = {pg, 1'b0, a[7:0]};
                3'd3: model_pc = {pg, 1'b0, lb};
                3'd4: model_pc = ra;
                default: model_pc = model_pc + 10'd1;
            endcase
        end
        e.pc = model_pc;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            logic [9:0] exp_p1;
            e = sb_q.pop_front();
            vectors++;
            if (pc_o !== e.pc) begin
                miscompares++;
                $display("FAIL %s pc_o actual=%h expected=%h", e.tag, pc_o, e.pc);
            end
            exp_p1 = e.pc + 10'd1;
            vectors++;
            if (pc_plus1_o !== exp_p1) begin
                miscompares++;
                $display("FAIL R8 pc_plus1_o actual=%h expected=%h", pc_plus1_o, exp_p1);
            end
        end
    end

    bit done = 1'b0;

    initial begin
        #400000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cyc_en = 1'b0; src_sel = 3'd0; addr_field = '0;
        low_byte = '0; page_bit = 1'b0; ret_addr = '0; model_pc = 10'h3FF;
        apply(1, 0, 3'd0, 9'h000, 8'h00, 0, 10'h000, "R1");
        apply(0, 1, 3'd0, 9'h000, 8'h00, 0, 10'h000, "R3 wrap");
        apply(0, 1, 3'd0, 9'h000, 8'h00, 0, 10'h000, "R3");
        apply(0, 1, 3'd0, 9'h000, 8'h00, 1, 10'h000, "R3");
        apply(0, 0, 3'd1, 9'h1AB, 8'h55, 1, 10'h123, "R2");
        apply(0, 0, 3'd4, 9'h000, 8'h00, 0, 10'h2EE, "R2");
        apply(0, 1, 3'd1, 9'h1AB, 8'h00, 0, 10'h000, "R4 page0");
        apply(0, 1, 3'd1, 9'h055, 8'h00, 1, 10'h000, "R4 page1");
        apply(0, 1, 3'd2, 9'h1CD, 8'h00, 1, 10'h000, "R5 bit8 dropped");
        apply(0, 1, 3'd2, 9'h1FF, 8'h00, 0, 10'h000, "R5 page0");
        apply(0, 1, 3'd3, 9'h1AA, 8'hF0, 0, 10'h000, "R6 page0");
        apply(0, 1, 3'd3, 9'h000, 8'h3C, 1, 10'h000, "R6 page1");
        apply(0, 1, 3'd4, 9'h000, 8'h00, 0, 10'h3A5, "R7 page ignored");
        apply(0, 1, 3'd4, 9'h000, 8'h00, 1, 10'h0A5, "R7 page ignored");
        apply(0, 1, 3'd0, 9'h1FF, 8'hFF, 1, 10'h3FF, "R3");
        apply(0, 1, 3'd5, 9'h1FF, 8'hFF, 1, 10'h3FF, "R10 code5");
        apply(0, 1, 3'd6, 9'h1FF, 8'hFF, 1, 10'h3FF, "R10 code6");
        apply(0, 1, 3'd7, 9'h1FF, 8'hFF, 1, 10'h3FF, "R10 code7");
        apply(1, 0, 3'd1, 9'h0AA, 8'h00, 1, 10'h000, "R9 over idle");
        apply(0, 1, 3'd1, 9'h0AA, 8'h00, 1, 10'h000, "R4");
        apply(1, 1, 3'd4, 9'h000, 8'h00, 1, 10'h155, "R9 over return");
        apply(0, 1, 3'd0, 9'h000, 8'h00, 0, 10'h000, "R3 wrap");
        apply(0, 1, 3'd1, 9'h1FF, 8'h00, 1, 10'h000, "R4 last word");
        apply(0, 1, 3'd0, 9'h000, 8'h00, 1, 10'h000, "R3 wrap after jump");
        apply(0, 0, 3'd0, 9'h000, 8'h00, 0, 10'h000, "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule